// File: doc/BRIEF.md
# Packet Payload XOR Scrambler

This block sits in a 64-bit packet pipeline and scrambles the payload of each packet by XORing it with a 32-bit key. Every packet arrives as a fixed 42-byte header region followed by the payload. The header region is an 8-byte shim, a 14-byte Ethernet header and a 20-byte IPv4 header without options. The header bytes leave the block untouched. The payload starts in the middle of the sixth bus word, so a single word can carry both header bytes and scrambled bytes.

Data moves with ready/valid flow control. Each beat carries start and end markers and one valid flag per byte. The block has one pipeline register, so a beat comes out one cycle after it is accepted. Software loads the key through a simple write strobe. A newly written key is held back and only takes effect at the next packet start, so one packet never mixes two keys.

Top module: `pkt_xor_scrambler`

## Requirements
- R1: Packet bytes at offsets 0 to 41 leave the block unchanged. This includes the first two byte lanes of beat 5 (beat 0 carries the start marker). A packet that ends before offset 42 leaves the block entirely unchanged.
- R2: A payload byte at offset 42 or later in byte lane L is XORed with key bits [31-8*(L mod 4) -: 8]. Lane 0 is the first byte on the wire and sits on data bits 63:56. Lane L occupies bits [63-8L -: 8].
- R3: With key 0xFFFFFFFF, every valid payload byte comes out bitwise inverted.
- R4: With key 0xFF00FF00, valid payload bytes in lanes 0, 2, 4 and 6 are inverted, and those in lanes 1, 3, 5 and 7 pass unchanged.
- R5: With key 0x55555555, every valid payload byte is XORed with 0x55, which inverts every other bit.
- R6: A key write takes effect at the next accepted start-of-packet beat. A write made mid-packet does not change the rest of that packet. A write made in the same cycle as an accepted start beat applies only to the following packet.
- R7: The start marker, end marker and per-byte valid flags come out exactly as they went in. A byte whose valid flag is 0 leaves unchanged. Valid flag bit i qualifies data bits [8i+7:8i].
- R8: A beat accepted at a clock edge (in_valid and in_ready both high) appears at the outputs with out_valid high directly after that edge.
- R9: While out_valid is high and out_ready is low, all outputs hold steady and in_ready is low.
- R10: After reset, out_valid is 0, in_ready is 1 and the key is zero. A packet sent before any key write therefore passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_wr_en | input | 1 | Key write strobe |
| key_wr_data | input | 32 | Key value to load |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be accepted |
| in_data | input | 64 | Input data, first wire byte on bits 63:56 |
| in_keep | input | 8 | Per-byte valid flags, bit i for bits 8i+7:8i |
| in_sop | input | 1 | First beat of packet |
| in_eop | input | 1 | Last beat of packet |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts output beat |
| out_data | output | 64 | Output data, scrambled payload |
| out_keep | output | 8 | Per-byte valid flags, passed through |
| out_sop | output | 1 | First beat marker, passed through |
| out_eop | output | 1 | Last beat marker, passed through |

## Verification
Two events can land in the same cycle: a key write, and the acceptance of a start-of-packet beat. In that case the packet starting now must use the key loaded earlier, and the new value must wait for the following packet. The bench raises the write strobe on the very cycle it drives a start beat. It then checks that the payload of that packet matches the older key and that the next packet matches the newer one. A second case writes the key on a payload beat in mid-packet, and the bench confirms that the remaining beats keep the key the packet started with.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

   typedef enum logic {
      LANE_MSB_FIRST = 1'b0,
      LANE_LSB_FIRST = 1'b1
   } lane_order_e;

   // byte position on the bus -> wire order lane
   function automatic int lane_of(input int byte_pos, input int lanes, input lane_order_e order);
      return (order == LANE_MSB_FIRST) ? (lanes - 1 - byte_pos) : byte_pos;
   endfunction

endpackage

// File: rtl/pxs_offset_tracker.sv
module pxs_offset_tracker #(
   parameter int IDX_W = 3,
   parameter int LIMIT = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             beat_fire,
   input  logic             beat_sop,
   input  logic             beat_eop,
   output logic [IDX_W-1:0] beat_idx
);
   localparam logic [IDX_W-1:0] LIM = IDX_W'(LIMIT);

   logic [IDX_W-1:0] cnt_q;

   // a start beat always restarts the word count
   assign beat_idx = beat_sop ? '0 : cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (beat_fire) begin
         if (beat_eop)
            cnt_q <= '0;
         else if (beat_idx == LIM)
            cnt_q <= LIM;
         else
            cnt_q <= beat_idx + 1'b1;
      end
   end
endmodule

// File: rtl/pxs_key_hold.sv
module pxs_key_hold #(
   parameter int KEY_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [KEY_W-1:0] wr_data,
   input  logic             beat_sop,
   input  logic             sop_fire,
   output logic [KEY_W-1:0] key_now,
   output logic [KEY_W-1:0] key_act
);
   logic [KEY_W-1:0] key_pend;

   // the start beat already sees the pending key
   assign key_now = beat_sop ? key_pend : key_act;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         key_pend <= '0;
         key_act  <= '0;
      end else begin
         if (wr_en)
            key_pend <= wr_data;
         if (sop_fire)
            key_act <= key_pend;
      end
   end
endmodule

// File: rtl/pxs_lane_xor.sv
module pxs_lane_xor
   import pxs_pkg::*;
#(
   parameter int          DATA_W    = 64,
   parameter int          KEY_W     = 32,
   parameter int          HDR_BYTES = 42,
   parameter int          IDX_W     = 3,
   parameter lane_order_e ORDER     = LANE_MSB_FIRST
) (
   input  logic [DATA_W-1:0]   data_i,
   input  logic [DATA_W/8-1:0] keep_i,
   input  logic [IDX_W-1:0]    idx_i,
   input  logic [KEY_W-1:0]    key_i,
   output logic [DATA_W-1:0]   data_o
);
   localparam int LANES    = DATA_W / 8;
   localparam int REP      = DATA_W / KEY_W;
   localparam int HDR_WORD = HDR_BYTES / LANES;
   localparam int HDR_LANE = HDR_BYTES % LANES;
   localparam logic [IDX_W-1:0] SPLIT_IDX = IDX_W'(HDR_WORD);

   logic [DATA_W-1:0] key_rep;
   logic              past_split;
   logic              at_split;

   assign key_rep    = {REP{key_i}};
   assign past_split = (idx_i > SPLIT_IDX);
   assign at_split   = (idx_i == SPLIT_IDX);

   for (genvar i = 0; i < LANES; i++) begin : g_byte
      localparam int LANE = lane_of(i, LANES, ORDER);
      logic pay;
      if (LANE >= HDR_LANE) begin : g_after
         assign pay = past_split | at_split;
      end else begin : g_before
         assign pay = past_split;
      end
      assign data_o[8*i +: 8] = (pay && keep_i[i]) ? (data_i[8*i +: 8] ^ key_rep[8*i +: 8])
                                                   : data_i[8*i +: 8];
   end
endmodule

// File: rtl/pkt_xor_scrambler.sv
module pkt_xor_scrambler
   import pxs_pkg::*;
#(
   parameter int          DATA_W     = 64,
   parameter int          KEY_W      = 32,
   parameter int          HDR_BYTES  = 42,
   parameter lane_order_e LANE_ORDER = LANE_MSB_FIRST
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                key_wr_en,
   input  logic [KEY_W-1:0]    key_wr_data,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [DATA_W-1:0]   in_data,
   input  logic [DATA_W/8-1:0] in_keep,
   input  logic                in_sop,
   input  logic                in_eop,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [DATA_W-1:0]   out_data,
   output logic [DATA_W/8-1:0] out_keep,
   output logic                out_sop,
   output logic                out_eop
);
   localparam int LANES    = DATA_W / 8;
   localparam int HDR_WORD = HDR_BYTES / LANES;
   localparam int IDX_W    = $clog2(HDR_WORD + 2);

   if (DATA_W % 8 != 0) begin : g_bad_data
      $error("DATA_W must be a whole number of bytes");
   end
   if (KEY_W % 8 != 0 || DATA_W % KEY_W != 0) begin : g_bad_key
      $error("KEY_W must be bytes and divide DATA_W");
   end
   if (HDR_BYTES < LANES) begin : g_bad_hdr
      $error("HDR_BYTES must cover at least one bus word");
   end

   logic              fire;
   logic [IDX_W-1:0]  beat_idx;
   logic [KEY_W-1:0]  key_now;
   logic [KEY_W-1:0]  key_act;
   logic [DATA_W-1:0] scr_data;

   assign in_ready = out_ready || !out_valid;
   assign fire     = in_valid && in_ready;

   pxs_offset_tracker #(
      .IDX_W (IDX_W),
      .LIMIT (HDR_WORD + 1)
   ) u_offs (
      .clk       (clk),
      .rst_n     (rst_n),
      .beat_fire (fire),
      .beat_sop  (in_sop),
      .beat_eop  (in_eop),
      .beat_idx  (beat_idx)
   );

   pxs_key_hold #(
      .KEY_W (KEY_W)
   ) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (key_wr_en),
      .wr_data  (key_wr_data),
      .beat_sop (in_sop),
      .sop_fire (fire && in_sop),
      .key_now  (key_now),
      .key_act  (key_act)
   );

   pxs_lane_xor #(
      .DATA_W    (DATA_W),
      .KEY_W     (KEY_W),
      .HDR_BYTES (HDR_BYTES),
      .IDX_W     (IDX_W),
      .ORDER     (LANE_ORDER)
   ) u_xor (
      .data_i (in_data),
      .keep_i (in_keep),
      .idx_i  (beat_idx),
      .key_i  (key_now),
      .data_o (scr_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_keep  <= '0;
         out_sop   <= 1'b0;
         out_eop   <= 1'b0;
      end else if (fire) begin
         out_valid <= 1'b1;
         out_data  <= scr_data;
         out_keep  <= in_keep;
         out_sop   <= in_sop;
         out_eop   <= in_eop;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/pxs_checker.sv
module pxs_checker #(
   parameter int DATA_W = 64,
   parameter int KEY_W  = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                in_ready,
   input logic [DATA_W-1:0]   in_data,
   input logic [DATA_W/8-1:0] in_keep,
   input logic                in_sop,
   input logic                in_eop,
   input logic                out_valid,
   input logic                out_ready,
   input logic [DATA_W-1:0]   out_data,
   input logic [DATA_W/8-1:0] out_keep,
   input logic                out_sop,
   input logic                out_eop,
   input logic [KEY_W-1:0]    key_act
);
   logic              fire;
   logic [DATA_W-1:0] omask;

   assign fire = in_valid && in_ready;
   for (genvar i = 0; i < DATA_W/8; i++) begin : g_m
      assign omask[8*i +: 8] = {8{out_keep[i]}};
   end

   p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> out_valid);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_keep)
                                     && $stable(out_sop) && $stable(out_eop)));

   p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   p_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (out_keep == $past(in_keep) && out_sop == $past(in_sop) && out_eop == $past(in_eop)));

   p_unkept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (((out_data ^ $past(in_data)) & ~omask) == '0));

   p_first_hdr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && in_sop) |=> (out_data == $past(in_data)));

   p_key_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(fire && in_sop) |=> $stable(key_act));
endmodule

bind pkt_xor_scrambler pxs_checker #(
   .DATA_W (DATA_W),
   .KEY_W  (KEY_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_data   (in_data),
   .in_keep   (in_keep),
   .in_sop    (in_sop),
   .in_eop    (in_eop),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_keep  (out_keep),
   .out_sop   (out_sop),
   .out_eop   (out_eop),
   .key_act   (key_act)
);

// File: tb/sim_pkt_xor_scrambler.sv
`timescale 1ns/1ps
module sim_pkt_xor_scrambler;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        key_wr_en = 1'b0;
   logic [31:0] key_wr_data = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [63:0] in_data = '0;
   logic [7:0]  in_keep = '0;
   logic        in_sop = 1'b0;
   logic        in_eop = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [63:0] out_data;
   logic [7:0]  out_keep;
   logic        out_sop;
   logic        out_eop;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   pkt_xor_scrambler u0 (
      .clk(clk), .rst_n(rst_n), .key_wr_en(key_wr_en), .key_wr_data(key_wr_data),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_keep(in_keep),
      .in_sop(in_sop), .in_eop(in_eop), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_keep(out_keep), .out_sop(out_sop), .out_eop(out_eop)
   );

   // stimulus table: key, beats, final keep, data seed
   localparam int NT = 5;
   localparam logic [31:0] T_KEY  [NT] = '{32'hFFFF_FFFF, 32'hFF00_FF00, 32'h5555_5555, 32'hA5C3_0F96, 32'h1234_5678};
   localparam int          T_LEN  [NT] = '{7, 6, 8, 6, 9};
   localparam logic [7:0]  T_LKEEP[NT] = '{8'hF0, 8'hFF, 8'h80, 8'hC0, 8'hFF};
   localparam logic [7:0]  T_SEED [NT] = '{8'h10, 8'h40, 8'h00, 8'h70, 8'h21};
   localparam string       T_TAG  [NT] = '{"R3", "R4", "R5", "R1", "R2"};

   function automatic logic [63:0] mk_word(input logic [7:0] seed, input int b);
      logic [63:0] w;
      for (int l = 0; l < 8; l++) w[63-8*l -: 8] = seed + 8'(b*8 + l);
      return w;
   endfunction

   function automatic logic [63:0] exp_word(input logic [63:0] w, input int b,
                                            input logic [7:0] keep, input logic [31:0] key);
      logic [63:0] r = w;
      for (int l = 0; l < 8; l++) begin
         if (b*8 + l >= 42 && keep[7-l])
            r[63-8*l -: 8] = w[63-8*l -: 8] ^ key[31-8*(l%4) -: 8];
      end
      return r;
   endfunction

   task automatic check(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic write_key(input logic [31:0] k);
      @(negedge clk);
      key_wr_en = 1'b1; key_wr_data = k;
      @(negedge clk);
      key_wr_en = 1'b0;
   endtask

   // sends one packet a beat at a time and checks each output beat
   task automatic send_pkt(input logic [31:0] key, input int len, input logic [7:0] lkeep,
                           input logic [7:0] seed, input string tag,
                           input int wr_beat, input logic [31:0] wr_val);
      for (int b = 0; b < len; b++) begin
         logic [7:0]  kp;
         logic [63:0] w;
         logic [63:0] e;
         kp = (b == len-1) ? lkeep : 8'hFF;
         w  = mk_word(seed, b);
         e  = exp_word(w, b, kp, key);
         @(negedge clk);
         in_valid = 1'b1; in_data = w; in_keep = kp;
         in_sop = (b == 0); in_eop = (b == len-1);
         key_wr_en = (b == wr_beat); key_wr_data = wr_val;
         @(negedge clk);
         in_valid = 1'b0; key_wr_en = 1'b0;
         check(tag, out_valid && out_data == e && out_keep == kp &&
                    out_sop == (b == 0) && out_eop == (b == len-1) && in_ready,
               out_data, e);
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state at the ports
      check("R10 out_valid", out_valid == 1'b0, 64'(out_valid), 64'h0);
      check("R10 in_ready", in_ready == 1'b1, 64'(in_ready), 64'h1);
      // R10: zero key, packet passes unchanged
      send_pkt(32'h0, 7, 8'hFF, 8'h33, "R10", -1, '0);

      // table walk
      for (int t = 0; t < NT; t++) begin
         write_key(T_KEY[t]);
         send_pkt(T_KEY[t], T_LEN[t], T_LKEEP[t], T_SEED[t], T_TAG[t], -1, '0);
      end

      // R6: mid-packet write keeps old key, next packet takes new
      write_key(32'hDEAD_BEEF);
      send_pkt(32'hDEAD_BEEF, 8, 8'hFF, 8'h05, "R6 mid", 5, 32'h0BAD_F00D);
      // R6: write in same cycle as start beat goes to the following packet
      send_pkt(32'h0BAD_F00D, 7, 8'hFF, 8'h61, "R6 same", 0, 32'hC0FF_EE11);
      send_pkt(32'hC0FF_EE11, 7, 8'h3F, 8'h92, "R6 next", -1, '0);

      // R9/R8: backpressure hold
      begin
         logic [63:0] w0;
         logic [63:0] w1;
         w0 = mk_word(8'hA0, 0);
         w1 = mk_word(8'hA0, 1);
         @(negedge clk);
         out_ready = 1'b0;
         in_valid = 1'b1; in_data = w0; in_keep = 8'hFF; in_sop = 1'b1; in_eop = 1'b0;
         @(negedge clk);
         check("R8 valid after accept", out_valid == 1'b1, 64'(out_valid), 64'h1);
         check("R9 in_ready low", in_ready == 1'b0, 64'(in_ready), 64'h0);
         in_data = w1; in_sop = 1'b0;
         @(negedge clk);
         check("R9 held data", out_valid && out_data == w0 && out_sop, out_data, w0);
         out_ready = 1'b1;
         @(negedge clk);
         in_valid = 1'b0;
         check("R9 next beat after release", out_valid && out_data == w1 && !out_sop, out_data, w1);
         @(negedge clk);
         check("R8 idle", out_valid == 1'b0, 64'(out_valid), 64'h0);
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule